// File: doc/BRIEF.md
# Trip Fault Flag and Interrupt Latch

This block keeps the sticky fault status of a PWM protection stage and turns new faults into an interrupt. It watches a level-sensitive one-shot trip request, a level-sensitive cycle-by-cycle trip request and four single-cycle digital-compare event strobes: two for comparator channel A and two for channel B. Each source has its own sticky flag. Software reads all flags in one 16-bit word and clears them by writing ones to a clear port. An interrupt flag in bit 0 gates a one-clock interrupt pulse, so a burst of faults raises one pulse only.

The cycle-by-cycle source also has an internal hold condition that follows the PWM period. The hold sets as soon as the trip request is seen. It is released only when a time-base counter-zero strobe arrives while the request is low. While the hold is active, the cycle-by-cycle flag cannot be cleared. The one-shot flag ignores the period boundary and stays set until software clears it. If software clears the interrupt flag while an enabled cycle-by-cycle or one-shot flag remains set, the block issues a new pulse. This keeps the fault from being lost.

Top module: `trip_flag_latch`

## Requirements
- R1: `flags_o` bit 0 is the interrupt flag, bit 1 is cycle-by-cycle, bit 2 is one-shot, bits 3, 4, 5 and 6 are channel A event 1, channel A event 2, channel B event 1 and channel B event 2. Bits 15 to 7 always read 0.
- R2: After reset every flag is 0 and `irq_o` is low.
- R3: A cycle with `clr_we_i` high clears each flag whose bit in `clr_data_i` is 1, and the new value shows one cycle later. Bit positions in `clr_data_i` match `flags_o` bits 6 to 0. Zero bits in the write have no effect, and `clr_data_i` has no effect when `clr_we_i` is low.
- R4: If a flag's set event and a clear of that same flag land in the same cycle, the flag ends up set.
- R5: The cycle-by-cycle flag is 1 in the cycle after any cycle in which `cbc_trip_i` is high, including when a clear of it was written in that cycle.
- R6: The cycle-by-cycle hold condition is released only by a cycle with `ctr_zero_i` high and `cbc_trip_i` low. Until that happens, a clear of the cycle-by-cycle flag leaves it set, even after `cbc_trip_i` has dropped.
- R7: The one-shot flag sets when `ost_trip_i` is high. It stays set until it is cleared through the clear port, whatever `ctr_zero_i` does.
- R8: A high cycle on `dc_evt_i[k]` sets flag bit 3+k. Here k=0 is channel A event 1, k=1 is channel A event 2, k=2 is channel B event 1 and k=3 is channel B event 2.
- R9: `irq_o` rises for one clock, together with the interrupt flag, one cycle after a source flag makes a 0-to-1 transition while its enable is 1 and the interrupt flag is clear. `int_en_i` bit 0 enables cycle-by-cycle, bit 1 enables one-shot, and bits 2 to 5 enable `dc_evt_i` 0 to 3.
- R10: While the interrupt flag is set and not being cleared, `irq_o` stays low.
- R11: Suppose the interrupt flag is cleared while the cycle-by-cycle or one-shot flag stays set after that write and its enable is 1. Then `irq_o` pulses in the next cycle and the interrupt flag sets again.
- R12: A source whose enable is 0 still latches its flag but raises no pulse. When all flags are cleared together, no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cbc_trip_i | input | 1 | Cycle-by-cycle trip request, level |
| ost_trip_i | input | 1 | One-shot trip request, level |
| dc_evt_i | input | 4 | Digital-compare event strobes: A1, A2, B1, B2 |
| ctr_zero_i | input | 1 | Time-base counter at zero, one-cycle strobe |
| clr_we_i | input | 1 | Clear write enable |
| clr_data_i | input | 7 | Write-one-to-clear mask, aligned with flag bits 6..0 |
| int_en_i | input | 6 | Per-source interrupt enables |
| flags_o | output | 16 | Flag word |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default parameters: four digital-compare sources and a 16-bit flag word. With these values every implemented flag, the reserved field and each enable bit can be driven and observed through the ports. Directed sequences cover the following cases:
- a cycle-by-cycle trip held across clears;
- a clear after the request drops but before the counter-zero strobe;
- counter-zero strobes on a latched one-shot;
- re-firing after an interrupt-flag clear;
- a set and a clear in the same cycle;
- a source that is not enabled.

Seeded random traffic then mixes all of these against a cycle model of the requirements.

// File: rtl/trip_flag_pkg.sv
package trip_flag_pkg;
    // Source indices inside the source-flag vector (flag word bit = index + 1)
    localparam int unsigned SRC_CBC  = 0;
    localparam int unsigned SRC_OST  = 1;
    localparam int unsigned SRC_DC0  = 2;
    // Flag word bit of the interrupt flag
    localparam int unsigned FLAG_INT = 0;
    // Offset between source index and flag word bit
    localparam int unsigned SRC_OFS  = 1;
endpackage

// File: rtl/trip_cbc_hold.sv
module trip_cbc_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic zero_i,
    output logic hold_o
);
    typedef struct packed {
        logic hold;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trip_i) begin
            st_d.hold = 1'b1;
        end else if (zero_i) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
endmodule

// File: rtl/trip_flag_bank.sv
module trip_flag_bank #(
    parameter int unsigned N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] next_o,
    output logic [N_SRC-1:0] rise_o
);
    typedef struct packed {
        logic [N_SRC-1:0] flg;
    } bank_st_t;

    bank_st_t st_d, st_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // set has priority over a simultaneous clear
        always_comb begin
            st_d.flg[i] = set_i[i] | (st_q.flg[i] & ~clr_i[i]);
            rise_o[i]   = set_i[i] & ~st_q.flg[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flg;
    assign next_o = st_d.flg;
endmodule

// File: rtl/trip_irq_gate.sv
module trip_irq_gate
    import trip_flag_pkg::*;
#(
    parameter int unsigned N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] rise_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] next_flag_i,
    input  logic             int_clr_i,
    output logic             int_o,
    output logic             irq_o
);
    typedef struct packed {
        logic int_flag;
        logic irq;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     int_base;
    logic     new_evt;
    logic     rearm;
    logic     fire;

    always_comb begin
        int_base = st_q.int_flag & ~int_clr_i;
        new_evt  = |(rise_i & en_i);
        rearm    = int_clr_i & st_q.int_flag &
                   ((next_flag_i[SRC_CBC] & en_i[SRC_CBC]) |
                    (next_flag_i[SRC_OST] & en_i[SRC_OST]));
        fire     = ~int_base & (new_evt | rearm);
        st_d.int_flag = int_base | fire;
        st_d.irq      = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_o = st_q.int_flag;
    assign irq_o = st_q.irq;
endmodule

// File: rtl/trip_flag_latch.sv
module trip_flag_latch
    import trip_flag_pkg::*;
#(
    parameter int unsigned FLAG_W = 16,
    parameter int unsigned N_DC   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cbc_trip_i,
    input  logic                       ost_trip_i,
    input  logic [N_DC-1:0]            dc_evt_i,
    input  logic                       ctr_zero_i,
    input  logic                       clr_we_i,
    input  logic [N_DC+SRC_DC0:0]      clr_data_i,
    input  logic [N_DC+SRC_DC0-1:0]    int_en_i,
    output logic [FLAG_W-1:0]          flags_o,
    output logic                       irq_o
);
    localparam int unsigned N_SRC  = SRC_DC0 + N_DC;
    localparam int unsigned N_USED = N_SRC + SRC_OFS;

    logic [N_USED-1:0] clr_vec;
    logic [N_SRC-1:0]  src_set;
    logic [N_SRC-1:0]  src_flag;
    logic [N_SRC-1:0]  src_next;
    logic [N_SRC-1:0]  src_rise;
    logic              cbc_hold;
    logic              int_flag;

    assign clr_vec = clr_we_i ? clr_data_i : '0;

    trip_cbc_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip_i (cbc_trip_i),
        .zero_i (ctr_zero_i),
        .hold_o (cbc_hold)
    );

    always_comb begin
        src_set                = '0;
        src_set[SRC_CBC]       = cbc_trip_i | cbc_hold;
        src_set[SRC_OST]       = ost_trip_i;
        src_set[SRC_DC0 +: N_DC] = dc_evt_i;
    end

    trip_flag_bank #(.N_SRC(N_SRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .clr_i  (clr_vec[N_USED-1:SRC_OFS]),
        .flag_o (src_flag),
        .next_o (src_next),
        .rise_o (src_rise)
    );

    trip_irq_gate #(.N_SRC(N_SRC)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (src_rise),
        .en_i        (int_en_i),
        .next_flag_i (src_next),
        .int_clr_i   (clr_vec[FLAG_INT]),
        .int_o       (int_flag),
        .irq_o       (irq_o)
    );

    for (genvar b = 0; b < FLAG_W; b++) begin : g_word
        if (b == FLAG_INT) begin : g_int
            assign flags_o[b] = int_flag;
        end else if (b < N_USED) begin : g_src
            assign flags_o[b] = src_flag[b-SRC_OFS];
        end else begin : g_rsv
            assign flags_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/trip_flag_checker.sv
module trip_flag_checker #(
    parameter int unsigned FLAG_W = 16,
    parameter int unsigned N_SRC  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cbc_trip_i,
    input logic              clr_we_i,
    input logic [N_SRC:0]    clr_data_i,
    input logic [N_SRC-1:0]  int_en_i,
    input logic [FLAG_W-1:0] flags_o,
    input logic              irq_o
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FLAG_W-1:N_SRC+1] == '0);

    p_cbc_relatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cbc_trip_i |=> flags_o[1]);

    p_ost_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[2] && !(clr_we_i && clr_data_i[2])) |=> flags_o[2]);

    p_irq_with_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_o[0] && (|flags_o[N_SRC:1])));

    p_quiet_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[0] && !(clr_we_i && clr_data_i[0])) |=> !irq_o);

    p_rearm_ost_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[0] && clr_we_i && clr_data_i[0] && flags_o[2] &&
         !clr_data_i[2] && int_en_i[1]) |=> irq_o);
endmodule

bind trip_flag_latch trip_flag_checker #(.FLAG_W(FLAG_W), .N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cbc_trip_i (cbc_trip_i),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .int_en_i   (int_en_i),
    .flags_o    (flags_o),
    .irq_o      (irq_o)
);

// File: tb/trip_flag_latch_test.sv
module trip_flag_latch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cbc_trip_i = 1'b0;
    logic        ost_trip_i = 1'b0;
    logic [3:0]  dc_evt_i = '0;
    logic        ctr_zero_i = 1'b0;
    logic        clr_we_i = 1'b0;
    logic [6:0]  clr_data_i = '0;
    logic [5:0]  int_en_i = '0;
    logic [15:0] flags_o;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;

    // model state
    logic [5:0] m_flg = '0;
    logic       m_hold = 1'b0;
    logic       m_int = 1'b0;
    logic       m_irq = 1'b0;

    always #4 clk = ~clk;

    trip_flag_latch uut (
        .clk(clk), .rst_n(rst_n), .cbc_trip_i(cbc_trip_i), .ost_trip_i(ost_trip_i),
        .dc_evt_i(dc_evt_i), .ctr_zero_i(ctr_zero_i), .clr_we_i(clr_we_i),
        .clr_data_i(clr_data_i), .int_en_i(int_en_i), .flags_o(flags_o), .irq_o(irq_o)
    );

    function automatic logic [15:0] model_word();
        return {9'b0, m_flg, m_int};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [5:0] set, clr, rise, nxt;
        logic ic, base, trig, fire;
        set  = {dc_evt_i, ost_trip_i, cbc_trip_i | m_hold};
        clr  = clr_we_i ? clr_data_i[6:1] : 6'b0;
        ic   = clr_we_i & clr_data_i[0];
        rise = set & ~m_flg & int_en_i;
        nxt  = set | (m_flg & ~clr);
        base = m_int & ~ic;
        trig = (|rise) | (ic & m_int & ((nxt[0] & int_en_i[0]) | (nxt[1] & int_en_i[1])));
        fire = ~base & trig;
        m_flg  = nxt;
        m_hold = cbc_trip_i | (m_hold & ~ctr_zero_i);
        m_int  = base | fire;
        m_irq  = fire;
    endtask

    task automatic drive(input logic cbc, input logic ost, input logic [3:0] dc,
                         input logic zero, input logic we, input logic [6:0] data);
        cbc_trip_i = cbc; ost_trip_i = ost; dc_evt_i = dc;
        ctr_zero_i = zero; clr_we_i = we; clr_data_i = data;
    endtask

    // one clock: update model at the edge, compare 1 ns later, then go idle
    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        check("R3 flags vs model", flags_o, model_word());
        check("R9 irq vs model", {15'b0, irq_o}, {15'b0, m_irq});
        drive(0, 0, 4'b0, 0, 0, 7'b0);
    endtask

    task automatic expect_out(input string tag, input logic [15:0] f, input logic i);
        check(tag, flags_o, f);
        check(tag, {15'b0, irq_o}, {15'b0, i});
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        expect_out("R2 reset", 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        int_en_i = 6'h3F;
        #1;

        // R8 / R9: channel A event 1 latches and fires
        drive(0, 0, 4'b0001, 0, 0, 7'h00); tick();
        expect_out("R8 R9 dc A1 latch and pulse", 16'h0009, 1'b1);
        tick();
        expect_out("R9 pulse one cycle", 16'h0009, 1'b0);
        // R10: second event while interrupt flag set
        drive(0, 0, 4'b1000, 0, 0, 7'h00); tick();
        expect_out("R10 no pulse while int set", 16'h0049, 1'b0);
        // R3: write enable low ignores data; zero bits keep flags
        drive(0, 0, 4'b0, 0, 0, 7'h7F); tick();
        expect_out("R3 no effect without enable", 16'h0049, 1'b0);
        drive(0, 0, 4'b0, 0, 1, 7'h40); tick();
        expect_out("R3 clear single bit", 16'h0009, 1'b0);
        drive(0, 0, 4'b0, 0, 1, 7'h09); tick();
        expect_out("R3 R12 clear all no pulse", 16'h0000, 1'b0);

        // R5 / R6: cycle-by-cycle
        drive(1, 0, 4'b0, 0, 0, 7'h00); tick();
        expect_out("R5 cbc latch and pulse", 16'h0003, 1'b1);
        drive(1, 0, 4'b0, 0, 1, 7'h02); tick();
        expect_out("R5 clear while trip high", 16'h0003, 1'b0);
        drive(1, 0, 4'b0, 1, 0, 7'h00); tick();
        drive(0, 0, 4'b0, 0, 1, 7'h02); tick();
        expect_out("R6 hold kept over zero with trip high", 16'h0003, 1'b0);
        drive(0, 0, 4'b0, 0, 1, 7'h02); tick();
        expect_out("R6 clear before zero strobe", 16'h0003, 1'b0);
        drive(0, 0, 4'b0, 1, 0, 7'h00); tick();
        expect_out("R6 zero strobe alone", 16'h0003, 1'b0);
        drive(0, 0, 4'b0, 0, 1, 7'h03); tick();
        expect_out("R6 R12 release after zero", 16'h0000, 1'b0);
        tick();
        expect_out("R12 silent after clearing all", 16'h0000, 1'b0);

        // R7 / R11: one-shot
        drive(0, 1, 4'b0, 0, 0, 7'h00); tick();
        expect_out("R7 ost latch and pulse", 16'h0005, 1'b1);
        drive(0, 0, 4'b0, 1, 0, 7'h00); tick();
        drive(0, 0, 4'b0, 1, 0, 7'h00); tick();
        expect_out("R7 zero strobe no effect", 16'h0005, 1'b0);
        drive(0, 0, 4'b0, 0, 1, 7'h01); tick();
        expect_out("R11 re-fire on int clear", 16'h0005, 1'b1);
        drive(0, 0, 4'b0, 0, 1, 7'h05); tick();
        expect_out("R12 clear both no pulse", 16'h0000, 1'b0);

        // R4: set beats clear
        drive(0, 0, 4'b0100, 0, 1, 7'h20); tick();
        expect_out("R4 set wins", 16'h0021, 1'b1);
        drive(0, 0, 4'b0, 0, 1, 7'h21); tick();

        // R12: disabled source
        int_en_i = 6'h00;
        drive(0, 0, 4'b0001, 0, 0, 7'h00); tick();
        expect_out("R12 disabled source latches only", 16'h0008, 1'b0);
        drive(0, 0, 4'b0, 0, 1, 7'h08); tick();
        expect_out("R3 cleared", 16'h0000, 1'b0);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            if ((n % 200) == 0) int_en_i = 6'($urandom);
            drive(($urandom % 8) == 0, ($urandom % 32) == 0,
                  4'($urandom) & 4'($urandom) & 4'($urandom),
                  ($urandom % 10) == 0, ($urandom % 4) == 0, 7'($urandom));
            tick();
            check("R1 reserved bits", {7'b0, flags_o[15:7]}, 16'h0000);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule